// File: doc/BRIEF.md
# Single-Precision Floating-Point Instruction Decoder

This block inspects one 32-bit instruction word and decides, without any clock, which single-precision floating-point operation it encodes. It hands the issue stage an operation code, the four register index fields, the three-bit rounding field and, for memory accesses, a sign-extended byte offset. It also reports which operands are read, whether each one comes from the integer or the floating-point register file, and where the result is written.

Any word outside the supported map, including a nonzero value in a field that must be zero, raises an illegal flag and yields the no-op code with every use and write flag clear. The conversions to and from 64-bit integers are accepted only when the integer width parameter is 64. The decoder does not resolve dynamic rounding, does not execute anything and does not touch a register file.

Top module: `fpdec_top`

## Requirements
- R1: Major opcode 0000111 with bits 14:12 = 010 decodes as an FP word load (op 1), and the offset is bits 31:20 sign-extended to the integer width; any other value in bits 14:12 is illegal.
- R2: Major opcode 0100111 with bits 14:12 = 010 decodes as an FP word store (op 2); offset bits 11:5 come from word bits 31:25 and offset bits 4:0 from word bits 11:7, sign-extended from bit 31.
- R3: Major opcodes 1000011, 1000111, 1001011 and 1001111 give fused multiply-add (3), multiply-subtract (4), negated multiply-subtract (5) and negated multiply-add (6), reading a third source from bits 31:27; a nonzero bits 26:25 is illegal.
- R4: Under major opcode 1010011, bits 31:25 equal to 0000000, 0000100, 0001000 and 0001100 give add (7), subtract (8), multiply (9) and divide (10); 0101100 gives square root (11) only when bits 24:20 are zero.
- R5: Bits 31:25 = 0010000 give sign injection copy (12), negate (13) and xor (14) for bits 14:12 = 000, 001, 010; bits 31:25 = 0010100 give minimum (15) for 000 and maximum (16) for 001; other bits 14:12 values are illegal.
- R6: Bits 31:25 = 1010000 give equal (17), less-than (18) and less-or-equal (19) for bits 14:12 = 010, 001, 000, writing an integer register; 011 is illegal.
- R7: Bits 31:25 = 1100000 convert float to integer and 1101000 integer to float, with bits 24:20 choosing signed word (00000), unsigned word (00001), signed long (00010) or unsigned long (00011); ops 20 to 23 and 24 to 27 in that order; other selector values are illegal.
- R8: The two long selectors decode as legal only when IntWidth is 64 and as illegal when it is 32.
- R9: Bits 31:25 = 1110000 with bits 24:20 zero give the raw move to an integer register (28) for bits 14:12 = 000 and classify (29) for 001; 1111000 with bits 24:20 zero and bits 14:12 = 000 gives the raw move into an FP register (30); every other combination is illegal.
- R10: An illegal word drives op 0, sets the illegal flag and clears every use and write flag and the offset.
- R11: The flags {useRs1, rs1Float, useRs2, rs2Float, useRs3, rdWrite, rdFloat} are 1000011 for load and integer-to-float ops, 1011000 for store, 1111111 for the fused family, 1111011 for two-source FP-result ops, 1100011 for square root, 1111010 for compares and 1100010 for float-to-integer, move-to-integer and classify; every legal word either writes a destination or is a store.
- R12: rs1, rs2, rs3, rd and the rounding field always mirror word bits 19:15, 24:20, 31:27, 11:7 and 14:12.
- R13: The offset output is zero for every word that is not a legal load or store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instrWord | input | 32 | Instruction word to decode |
| opCode | output | 5 | Operation code, 0 when illegal |
| illegal | output | 1 | Word is not a supported encoding |
| rs1Idx | output | 5 | First source index |
| rs2Idx | output | 5 | Second source index |
| rs3Idx | output | 5 | Third source index |
| rdIdx | output | 5 | Destination index |
| rmField | output | 3 | Raw rounding field |
| immValue | output | IntWidth | Sign-extended memory offset |
| useRs1 | output | 1 | First source is read |
| rs1Float | output | 1 | First source comes from the FP file |
| useRs2 | output | 1 | Second source is read |
| rs2Float | output | 1 | Second source comes from the FP file |
| useRs3 | output | 1 | Third source is read (FP file) |
| rdWrite | output | 1 | A destination is written |
| rdFloat | output | 1 | Destination is in the FP file |

## Verification
The block holds no state, so a wrong decision in the sub-decode shows at the ports in the same cycle the word is applied: a wrong op code, a missed illegal flag, or a flag telling the issue stage to read the wrong register file. Each funct7, funct3 and selector value is applied next to its illegal neighbours so a widened or shifted compare surfaces as a mismatch on the first word that exercises it. The long conversions are driven through both a 32-bit and a 64-bit instance to expose a gate that ignores the parameter.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;

  localparam logic [6:0] OPC_LOAD  = 7'b0000111;
  localparam logic [6:0] OPC_STORE = 7'b0100111;
  localparam logic [6:0] OPC_MADD  = 7'b1000011;
  localparam logic [6:0] OPC_MSUB  = 7'b1000111;
  localparam logic [6:0] OPC_NMSUB = 7'b1001011;
  localparam logic [6:0] OPC_NMADD = 7'b1001111;
  localparam logic [6:0] OPC_ARITH = 7'b1010011;

  typedef enum logic [4:0] {
    OP_NOP     = 5'd0,
    OP_LOAD    = 5'd1,
    OP_STORE   = 5'd2,
    OP_FMADD   = 5'd3,
    OP_FMSUB   = 5'd4,
    OP_FNMSUB  = 5'd5,
    OP_FNMADD  = 5'd6,
    OP_ADD     = 5'd7,
    OP_SUB     = 5'd8,
    OP_MUL     = 5'd9,
    OP_DIV     = 5'd10,
    OP_SQRT    = 5'd11,
    OP_SGNCPY  = 5'd12,
    OP_SGNNEG  = 5'd13,
    OP_SGNXOR  = 5'd14,
    OP_MIN     = 5'd15,
    OP_MAX     = 5'd16,
    OP_CMPEQ   = 5'd17,
    OP_CMPLT   = 5'd18,
    OP_CMPLE   = 5'd19,
    OP_F2I_W   = 5'd20,
    OP_F2I_WU  = 5'd21,
    OP_F2I_L   = 5'd22,
    OP_F2I_LU  = 5'd23,
    OP_I2F_W   = 5'd24,
    OP_I2F_WU  = 5'd25,
    OP_I2F_L   = 5'd26,
    OP_I2F_LU  = 5'd27,
    OP_BITS2I  = 5'd28,
    OP_CLASS   = 5'd29,
    OP_BITS2F  = 5'd30
  } fpOp_e;

  typedef struct packed {
    logic useRs1;
    logic rs1Float;
    logic useRs2;
    logic rs2Float;
    logic useRs3;
    logic rdWrite;
    logic rdFloat;
    logic immLoad;
    logic immStore;
  } fpStrobe_t;

endpackage

// File: rtl/fpdec_ctrl.sv
module fpdec_ctrl
  import fpdec_pkg::*;
#(
  parameter int IntWidth = 32
) (
  input  logic [6:0] opcodeField,
  input  logic [2:0] funct3,
  input  logic [4:0] rs2Sel,
  input  logic [6:0] funct7,
  output fpOp_e      opSel,
  output logic       illegal,
  output fpStrobe_t  strobe
);

  localparam bit LongOk = (IntWidth >= 64);

  logic longLegal;
  logic [1:0] fmtField;
  fpOp_e opNext;

  generate
    if (LongOk) begin : g_long
      assign longLegal = 1'b1;
    end else begin : g_word
      assign longLegal = 1'b0;
    end
  endgenerate

  assign fmtField = funct7[1:0];

  // Primary decode: opcode, then funct7, funct3 and the selector field.
  always_comb begin
    opNext = OP_NOP;
    case (opcodeField)
      OPC_LOAD:  if (funct3 == 3'b010) opNext = OP_LOAD;
      OPC_STORE: if (funct3 == 3'b010) opNext = OP_STORE;
      OPC_MADD:  if (fmtField == 2'b00) opNext = OP_FMADD;
      OPC_MSUB:  if (fmtField == 2'b00) opNext = OP_FMSUB;
      OPC_NMSUB: if (fmtField == 2'b00) opNext = OP_FNMSUB;
      OPC_NMADD: if (fmtField == 2'b00) opNext = OP_FNMADD;
      OPC_ARITH: begin
        case (funct7)
          7'b0000000: opNext = OP_ADD;
          7'b0000100: opNext = OP_SUB;
          7'b0001000: opNext = OP_MUL;
          7'b0001100: opNext = OP_DIV;
          7'b0101100: if (rs2Sel == 5'd0) opNext = OP_SQRT;
          7'b0010000: begin
            case (funct3)
              3'b000:  opNext = OP_SGNCPY;
              3'b001:  opNext = OP_SGNNEG;
              3'b010:  opNext = OP_SGNXOR;
              default: opNext = OP_NOP;
            endcase
          end
          7'b0010100: begin
            case (funct3)
              3'b000:  opNext = OP_MIN;
              3'b001:  opNext = OP_MAX;
              default: opNext = OP_NOP;
            endcase
          end
          7'b1010000: begin
            case (funct3)
              3'b010:  opNext = OP_CMPEQ;
              3'b001:  opNext = OP_CMPLT;
              3'b000:  opNext = OP_CMPLE;
              default: opNext = OP_NOP;
            endcase
          end
          7'b1100000: begin
            case (rs2Sel)
              5'd0:    opNext = OP_F2I_W;
              5'd1:    opNext = OP_F2I_WU;
              5'd2:    opNext = longLegal ? OP_F2I_L : OP_NOP;
              5'd3:    opNext = longLegal ? OP_F2I_LU : OP_NOP;
              default: opNext = OP_NOP;
            endcase
          end
          7'b1101000: begin
            case (rs2Sel)
              5'd0:    opNext = OP_I2F_W;
              5'd1:    opNext = OP_I2F_WU;
              5'd2:    opNext = longLegal ? OP_I2F_L : OP_NOP;
              5'd3:    opNext = longLegal ? OP_I2F_LU : OP_NOP;
              default: opNext = OP_NOP;
            endcase
          end
          7'b1110000: begin
            if (rs2Sel == 5'd0) begin
              case (funct3)
                3'b000:  opNext = OP_BITS2I;
                3'b001:  opNext = OP_CLASS;
                default: opNext = OP_NOP;
              endcase
            end
          end
          7'b1111000: if (rs2Sel == 5'd0 && funct3 == 3'b000) opNext = OP_BITS2F;
          default:    opNext = OP_NOP;
        endcase
      end
      default: opNext = OP_NOP;
    endcase
  end

  assign opSel   = opNext;
  assign illegal = (opNext == OP_NOP);

  // Operand and result routing per operation class.
  always_comb begin
    strobe = '0;
    case (opNext)
      OP_LOAD: begin
        strobe.useRs1 = 1'b1; strobe.rdWrite = 1'b1; strobe.rdFloat = 1'b1;
        strobe.immLoad = 1'b1;
      end
      OP_STORE: begin
        strobe.useRs1 = 1'b1; strobe.useRs2 = 1'b1; strobe.rs2Float = 1'b1;
        strobe.immStore = 1'b1;
      end
      OP_FMADD, OP_FMSUB, OP_FNMSUB, OP_FNMADD: begin
        strobe.useRs1 = 1'b1; strobe.rs1Float = 1'b1;
        strobe.useRs2 = 1'b1; strobe.rs2Float = 1'b1;
        strobe.useRs3 = 1'b1;
        strobe.rdWrite = 1'b1; strobe.rdFloat = 1'b1;
      end
      OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_SGNCPY, OP_SGNNEG, OP_SGNXOR,
      OP_MIN, OP_MAX: begin
        strobe.useRs1 = 1'b1; strobe.rs1Float = 1'b1;
        strobe.useRs2 = 1'b1; strobe.rs2Float = 1'b1;
        strobe.rdWrite = 1'b1; strobe.rdFloat = 1'b1;
      end
      OP_SQRT: begin
        strobe.useRs1 = 1'b1; strobe.rs1Float = 1'b1;
        strobe.rdWrite = 1'b1; strobe.rdFloat = 1'b1;
      end
      OP_CMPEQ, OP_CMPLT, OP_CMPLE: begin
        strobe.useRs1 = 1'b1; strobe.rs1Float = 1'b1;
        strobe.useRs2 = 1'b1; strobe.rs2Float = 1'b1;
        strobe.rdWrite = 1'b1;
      end
      OP_F2I_W, OP_F2I_WU, OP_F2I_L, OP_F2I_LU, OP_BITS2I, OP_CLASS: begin
        strobe.useRs1 = 1'b1; strobe.rs1Float = 1'b1;
        strobe.rdWrite = 1'b1;
      end
      OP_I2F_W, OP_I2F_WU, OP_I2F_L, OP_I2F_LU, OP_BITS2F: begin
        strobe.useRs1 = 1'b1;
        strobe.rdWrite = 1'b1; strobe.rdFloat = 1'b1;
      end
      default: strobe = '0;
    endcase
  end

  always_comb begin
    AST_ILLEGAL_QUIET: assert (!illegal || strobe == '0)
      else $error("illegal word left a strobe set"); // R10
    AST_LONG_GATED: assert (LongOk || !(opSel inside {OP_F2I_L, OP_F2I_LU, OP_I2F_L, OP_I2F_LU}))
      else $error("long conversion accepted at word width"); // R8
    AST_THIRD_SRC: assert (!strobe.useRs3 || (fmtField == 2'b00 &&
                    opcodeField inside {OPC_MADD, OPC_MSUB, OPC_NMSUB, OPC_NMADD}))
      else $error("third source outside fused family"); // R3
    AST_LEGAL_EFFECT: assert (illegal || strobe.rdWrite || strobe.immStore)
      else $error("legal word neither writes nor stores"); // R11
  end

endmodule

// File: rtl/fpdec_dp.sv
module fpdec_dp
  import fpdec_pkg::*;
#(
  parameter int IntWidth = 32
) (
  input  logic [31:7]         instrHi,
  input  fpStrobe_t           strobe,
  output logic [4:0]          rs1Idx,
  output logic [4:0]          rs2Idx,
  output logic [4:0]          rs3Idx,
  output logic [4:0]          rdIdx,
  output logic [2:0]          rmField,
  output logic [IntWidth-1:0] immValue
);

  localparam int ImmBits = 12;
  localparam int ExtBits = IntWidth - ImmBits;

  logic [ImmBits-1:0] loadOff;
  logic [ImmBits-1:0] storeOff;

  assign rs1Idx  = instrHi[19:15];
  assign rs2Idx  = instrHi[24:20];
  assign rs3Idx  = instrHi[31:27];
  assign rdIdx   = instrHi[11:7];
  assign rmField = instrHi[14:12];

  assign loadOff  = instrHi[31:20];
  assign storeOff = {instrHi[31:25], instrHi[11:7]};

  always_comb begin
    if (strobe.immLoad)
      immValue = {{ExtBits{loadOff[ImmBits-1]}}, loadOff};
    else if (strobe.immStore)
      immValue = {{ExtBits{storeOff[ImmBits-1]}}, storeOff};
    else
      immValue = '0;
  end

  always_comb begin
    AST_IMM_IDLE: assert (strobe.immLoad || strobe.immStore || immValue == '0)
      else $error("offset driven for non-memory word"); // R13
    AST_IMM_SIGN: assert (!(strobe.immLoad || strobe.immStore) ||
                          immValue[IntWidth-1] == instrHi[31])
      else $error("offset sign does not follow bit 31"); // R1
  end

endmodule

// File: rtl/fpdec_top.sv
module fpdec_top
  import fpdec_pkg::*;
#(
  parameter int IntWidth = 32
) (
  input  logic [31:0]         instrWord,
  output logic [4:0]          opCode,
  output logic                illegal,
  output logic [4:0]          rs1Idx,
  output logic [4:0]          rs2Idx,
  output logic [4:0]          rs3Idx,
  output logic [4:0]          rdIdx,
  output logic [2:0]          rmField,
  output logic [IntWidth-1:0] immValue,
  output logic                useRs1,
  output logic                rs1Float,
  output logic                useRs2,
  output logic                rs2Float,
  output logic                useRs3,
  output logic                rdWrite,
  output logic                rdFloat
);

  fpOp_e     opSel;
  fpStrobe_t strobe;

  fpdec_ctrl #(.IntWidth(IntWidth)) u_ctrl (
    .opcodeField (instrWord[6:0]),
    .funct3      (instrWord[14:12]),
    .rs2Sel      (instrWord[24:20]),
    .funct7      (instrWord[31:25]),
    .opSel       (opSel),
    .illegal     (illegal),
    .strobe      (strobe)
  );

  fpdec_dp #(.IntWidth(IntWidth)) u_dp (
    .instrHi  (instrWord[31:7]),
    .strobe   (strobe),
    .rs1Idx   (rs1Idx),
    .rs2Idx   (rs2Idx),
    .rs3Idx   (rs3Idx),
    .rdIdx    (rdIdx),
    .rmField  (rmField),
    .immValue (immValue)
  );

  assign opCode   = opSel;
  assign useRs1   = strobe.useRs1;
  assign rs1Float = strobe.rs1Float;
  assign useRs2   = strobe.useRs2;
  assign rs2Float = strobe.rs2Float;
  assign useRs3   = strobe.useRs3;
  assign rdWrite  = strobe.rdWrite;
  assign rdFloat  = strobe.rdFloat;

endmodule

// File: tb/fpdec_top_bench.sv
module fpdec_top_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] word, wideWord;
  logic [4:0]  opA, r1A, r2A, r3A, rdA;
  logic        illA, u1A, f1A, u2A, f2A, u3A, wA, wfA;
  logic [2:0]  rmA;
  logic [31:0] immA;
  logic [4:0]  opB, r1B, r2B, r3B, rdB;
  logic        illB, u1B, f1B, u2B, f2B, u3B, wB, wfB;
  logic [2:0]  rmB;
  logic [63:0] immB;

  fpdec_top u_fpdec_top (
    .instrWord(word), .opCode(opA), .illegal(illA), .rs1Idx(r1A), .rs2Idx(r2A),
    .rs3Idx(r3A), .rdIdx(rdA), .rmField(rmA), .immValue(immA), .useRs1(u1A),
    .rs1Float(f1A), .useRs2(u2A), .rs2Float(f2A), .useRs3(u3A), .rdWrite(wA),
    .rdFloat(wfA));

  fpdec_top #(.IntWidth(64)) u_fpdec_top_wide (
    .instrWord(wideWord), .opCode(opB), .illegal(illB), .rs1Idx(r1B), .rs2Idx(r2B),
    .rs3Idx(r3B), .rdIdx(rdB), .rmField(rmB), .immValue(immB), .useRs1(u1B),
    .rs1Float(f1B), .useRs2(u2B), .rs2Float(f2B), .useRs3(u3B), .rdWrite(wB),
    .rdFloat(wfB));

  // {opcode, funct7, rs2 field, funct3, op, illegal, flags}
  localparam int NumVec = 39;
  localparam logic [34:0] vecTab [NumVec] = '{
    {7'h07, 7'h00, 5'd0, 3'd2, 5'd1,  1'b0, 7'b1000011},
    {7'h07, 7'h00, 5'd0, 3'd3, 5'd0,  1'b1, 7'b0000000},
    {7'h27, 7'h00, 5'd0, 3'd2, 5'd2,  1'b0, 7'b1011000},
    {7'h43, 7'h14, 5'd4, 3'd0, 5'd3,  1'b0, 7'b1111111},
    {7'h47, 7'h14, 5'd4, 3'd0, 5'd4,  1'b0, 7'b1111111},
    {7'h4B, 7'h14, 5'd4, 3'd0, 5'd5,  1'b0, 7'b1111111},
    {7'h4F, 7'h14, 5'd4, 3'd0, 5'd6,  1'b0, 7'b1111111},
    {7'h43, 7'h15, 5'd4, 3'd0, 5'd0,  1'b1, 7'b0000000},
    {7'h53, 7'h00, 5'd4, 3'd0, 5'd7,  1'b0, 7'b1111011},
    {7'h53, 7'h04, 5'd4, 3'd0, 5'd8,  1'b0, 7'b1111011},
    {7'h53, 7'h08, 5'd4, 3'd0, 5'd9,  1'b0, 7'b1111011},
    {7'h53, 7'h0C, 5'd4, 3'd0, 5'd10, 1'b0, 7'b1111011},
    {7'h53, 7'h2C, 5'd0, 3'd0, 5'd11, 1'b0, 7'b1100011},
    {7'h53, 7'h2C, 5'd1, 3'd0, 5'd0,  1'b1, 7'b0000000},
    {7'h53, 7'h10, 5'd4, 3'd0, 5'd12, 1'b0, 7'b1111011},
    {7'h53, 7'h10, 5'd4, 3'd1, 5'd13, 1'b0, 7'b1111011},
    {7'h53, 7'h10, 5'd4, 3'd2, 5'd14, 1'b0, 7'b1111011},
    {7'h53, 7'h10, 5'd4, 3'd3, 5'd0,  1'b1, 7'b0000000},
    {7'h53, 7'h14, 5'd4, 3'd0, 5'd15, 1'b0, 7'b1111011},
    {7'h53, 7'h14, 5'd4, 3'd1, 5'd16, 1'b0, 7'b1111011},
    {7'h53, 7'h14, 5'd4, 3'd2, 5'd0,  1'b1, 7'b0000000},
    {7'h53, 7'h50, 5'd4, 3'd2, 5'd17, 1'b0, 7'b1111010},
    {7'h53, 7'h50, 5'd4, 3'd1, 5'd18, 1'b0, 7'b1111010},
    {7'h53, 7'h50, 5'd4, 3'd0, 5'd19, 1'b0, 7'b1111010},
    {7'h53, 7'h50, 5'd4, 3'd3, 5'd0,  1'b1, 7'b0000000},
    {7'h53, 7'h60, 5'd0, 3'd0, 5'd20, 1'b0, 7'b1100010},
    {7'h53, 7'h60, 5'd1, 3'd0, 5'd21, 1'b0, 7'b1100010},
    {7'h53, 7'h60, 5'd2, 3'd0, 5'd0,  1'b1, 7'b0000000},
    {7'h53, 7'h60, 5'd4, 3'd0, 5'd0,  1'b1, 7'b0000000},
    {7'h53, 7'h68, 5'd0, 3'd0, 5'd24, 1'b0, 7'b1000011},
    {7'h53, 7'h68, 5'd1, 3'd0, 5'd25, 1'b0, 7'b1000011},
    {7'h53, 7'h68, 5'd3, 3'd0, 5'd0,  1'b1, 7'b0000000},
    {7'h53, 7'h70, 5'd0, 3'd0, 5'd28, 1'b0, 7'b1100010},
    {7'h53, 7'h70, 5'd0, 3'd1, 5'd29, 1'b0, 7'b1100010},
    {7'h53, 7'h70, 5'd1, 3'd0, 5'd0,  1'b1, 7'b0000000},
    {7'h53, 7'h78, 5'd0, 3'd0, 5'd30, 1'b0, 7'b1000011},
    {7'h53, 7'h78, 5'd0, 3'd1, 5'd0,  1'b1, 7'b0000000},
    {7'h53, 7'h7F, 5'd0, 3'd0, 5'd0,  1'b1, 7'b0000000},
    {7'h33, 7'h00, 5'd0, 3'd0, 5'd0,  1'b1, 7'b0000000}
  };

  function automatic string reqOf(input logic [6:0] opc, input logic [6:0] f7);
    if (opc == 7'h07) return "R1";
    if (opc == 7'h27) return "R2";
    if (opc inside {7'h43, 7'h47, 7'h4B, 7'h4F}) return "R3";
    if (opc != 7'h53) return "R10";
    if (f7 inside {7'h00, 7'h04, 7'h08, 7'h0C, 7'h2C}) return "R4";
    if (f7 inside {7'h10, 7'h14}) return "R5";
    if (f7 == 7'h50) return "R6";
    if (f7 inside {7'h60, 7'h68}) return "R7";
    if (f7 inside {7'h70, 7'h78}) return "R9";
    return "R10";
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic applyBoth(input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    word = a;
    wideWord = b;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog expired: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    word = '0;
    wideWord = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state: all-zero word is not a legal encoding (R10)
    chk("R10", "zero word illegal", {63'd0, illA}, 64'd1);
    chk("R10", "zero word op", {59'd0, opA}, 64'd0);
    chk("R10", "zero word flags", {57'd0, u1A, f1A, u2A, f2A, u3A, wA, wfA}, 64'd0);
    rstN = 1'b1;

    for (int i = 0; i < NumVec; i++) begin
      logic [34:0] v;
      string tag;
      v = vecTab[i];
      tag = reqOf(v[34:28], v[27:21]);
      applyBoth({v[27:21], v[20:16], 5'd3, v[15:13], 5'd9, v[34:28]}, 32'd0);
      chk(tag, "op", {59'd0, opA}, {59'd0, v[12:8]});
      chk(tag, "illegal", {63'd0, illA}, {63'd0, v[7]});
      chk("R11", "flags", {57'd0, u1A, f1A, u2A, f2A, u3A, wA, wfA}, {57'd0, v[6:0]});
      if (v[7]) chk("R10", "offset on illegal", {32'd0, immA}, 64'd0);
    end

    // R1: negative load offset, sign extended to 32 and 64 bits
    applyBoth({12'hFFC, 5'd2, 3'b010, 5'd1, 7'h07}, {12'h800, 5'd2, 3'b010, 5'd1, 7'h07});
    chk("R1", "load offset 32", {32'd0, immA}, 64'h0000_0000_FFFF_FFFC);
    chk("R1", "load offset 64", immB, 64'hFFFF_FFFF_FFFF_F800);
    applyBoth({12'h7FF, 5'd2, 3'b010, 5'd1, 7'h07}, 32'd0);
    chk("R1", "positive load offset", {32'd0, immA}, 64'h7FF);

    // R2: split store offset
    applyBoth({7'b1000001, 5'd6, 5'd2, 3'b010, 5'b10101, 7'h27},
              {7'b0001001, 5'd6, 5'd2, 3'b010, 5'b00011, 7'h27});
    chk("R2", "store offset 32", {32'd0, immA}, 64'h0000_0000_FFFF_F835);
    chk("R2", "store offset 64", immB, 64'h123);

    // R12: index and rounding fields pass through
    applyBoth({5'd27, 2'b00, 5'd14, 5'd21, 3'b101, 5'd30, 7'h43}, 32'd0);
    chk("R12", "rs1", {59'd0, r1A}, 64'd21);
    chk("R12", "rs2", {59'd0, r2A}, 64'd14);
    chk("R12", "rs3", {59'd0, r3A}, 64'd27);
    chk("R12", "rd", {59'd0, rdA}, 64'd30);
    chk("R12", "rm", {61'd0, rmA}, 64'd5);
    chk("R13", "offset idle on fused op", {32'd0, immA}, 64'd0);

    // R8: long conversions legal only at 64-bit width
    applyBoth({7'h60, 5'd2, 5'd1, 3'd0, 5'd1, 7'h53}, {7'h60, 5'd2, 5'd1, 3'd0, 5'd1, 7'h53});
    chk("R8", "f2i long narrow illegal", {63'd0, illA}, 64'd1);
    chk("R8", "f2i long wide op", {59'd0, opB}, 64'd22);
    applyBoth({7'h60, 5'd3, 5'd1, 3'd0, 5'd1, 7'h53}, {7'h60, 5'd3, 5'd1, 3'd0, 5'd1, 7'h53});
    chk("R8", "f2i ulong narrow op", {59'd0, opA}, 64'd0);
    chk("R8", "f2i ulong wide op", {59'd0, opB}, 64'd23);
    applyBoth(32'd0, {7'h68, 5'd2, 5'd1, 3'd0, 5'd1, 7'h53});
    chk("R8", "i2f long wide op", {59'd0, opB}, 64'd26);
    chk("R11", "i2f long wide flags", {57'd0, u1B, f1B, u2B, f2B, u3B, wB, wfB}, 64'b1000011);
    applyBoth(32'd0, {7'h68, 5'd3, 5'd1, 3'd0, 5'd1, 7'h53});
    chk("R8", "i2f ulong wide op", {59'd0, opB}, 64'd27);
    applyBoth(32'd0, {7'h68, 5'd4, 5'd1, 3'd0, 5'd1, 7'h53});
    chk("R7", "i2f selector 4 wide illegal", {63'd0, illB}, 64'd1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule